// File: doc/BRIEF.md
# Serial Receiver with Standby Wakeup

This block turns an asynchronous serial input line into characters. A baud tick from outside, asserted for one clock at sixteen times the bit rate, paces the sampling. Every bit is settled by a vote of three samples taken around its centre. Three configuration inputs choose the character shape: one selects a long or short character, one turns parity on, and one picks odd or even parity. When parity is on, the parity bit takes the most significant position of the character and does not add a bit to the frame.

Software can place the receiver in standby with a one-cycle request. While in standby, received characters are not announced. Standby ends in one of two ways, chosen by a configuration input. In address-mark mode, a character whose top bit is 1 ends standby, and that character is delivered. In idle-line mode, a full character time of continuous 1s on the line ends standby. Another input decides where the idle count starts: at the end of the start bit, or only after the stop bit. The second choice stops trailing 1s in the data from looking like an idle line.

Top module: `uart_wake_rx`

## Requirements
- R1: With cfg_len9=0 and cfg_par_en=0 a frame is a low start bit, 8 data bits sent LSB first, then a stop bit; rx_data[7:0] holds the data, rx_data[8] is 0, and rx_valid pulses for one clock per character.
- R2: With cfg_len9=1 and cfg_par_en=0 a frame carries 9 data bits, LSB first, all of them presented on rx_data[8:0].
- R3: With cfg_len9=0 and cfg_par_en=1 a frame carries 7 data bits followed by a parity bit; the parity bit appears in rx_data[7], and err_parity is set when the count of 1s over rx_data[7:0] does not match the selected sense.
- R4: With cfg_len9=1 and cfg_par_en=1 a frame carries 8 data bits followed by a parity bit in rx_data[8], checked over rx_data[8:0].
- R5: cfg_par_odd=1 requires an odd total count of 1s and cfg_par_odd=0 an even one; with cfg_par_en=0, err_parity stays 0 whatever cfg_par_odd is.
- R6: A stop bit decided as 0 sets err_frame together with that character's rx_valid, and the next correct character clears it; err_frame and err_parity change only when rx_valid pulses.
- R7: Each bit is the majority of samples 7, 8 and 9 of its 16, so one wrong sample among them has no effect while two invert the bit. A low pulse that does not last to mid-bit is rejected as a start bit and produces no character.
- R8: A one-clock sleep_req sets standby. With cfg_wake_addr=1, characters whose top bit (rx_data[7] when cfg_len9=0, rx_data[8] when cfg_len9=1) is 0 raise no rx_valid, and idle lines leave standby set. The first character whose top bit is 1 is delivered and clears standby.
- R9: With cfg_wake_addr=0, characters received in standby raise no rx_valid, and the idle detection clears standby.
- R10: idle_flag pulses after one character length (10 bit times when cfg_len9=0, 11 when 1) of continuous 1s. With cfg_idle_after_stop=0, the count starts after the start bit, so 1s in the data count. With cfg_idle_after_stop=1, the count starts after the stop bit.
- R11: idle_flag pulses once per idle period. It is armed again only by an accepted start bit, and there is no idle pulse after reset until a start bit has been accepted.
- R12: Changing cfg_par_odd in the middle of a character may flag that character, but the receiver keeps going and decodes the next character correctly.
- R13: After reset, rx_valid, rx_data, err_parity, err_frame, idle_flag and standby are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | One-clock tick at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len9 | input | 1 | 1 selects the long character, 0 the short one |
| cfg_par_en | input | 1 | 1 turns on parity in the top character bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_wake_addr | input | 1 | 1 selects address-mark wakeup, 0 idle-line wakeup |
| cfg_idle_after_stop | input | 1 | 1 starts the idle count after the stop bit, 0 after the start bit |
| sleep_req | input | 1 | One-clock request to enter standby |
| rx_data | output | 9 | Last delivered character, parity bit included |
| rx_valid | output | 1 | One-clock strobe for a delivered character |
| err_parity | output | 1 | Parity error of the last delivered character |
| err_frame | output | 1 | Framing error of the last delivered character |
| idle_flag | output | 1 | One-clock strobe when an idle line is detected |
| standby | output | 1 | Receiver is in standby |

## Verification
The assertions take for granted that samp_en pulses are separated by at least several clocks, so two characters can never finish on neighbouring clocks. They also assume that sleep_req is the only way into standby, and that the configuration inputs do not change while a wakeup decision is being made. The stimulus meets these conditions. The bench raises the tick once every four clocks and holds each line level for four clocks per sample. It pulses sleep_req only while the line is idle, and it changes the configuration only between frames, except for the one deliberate mid-character parity flip.

// File: rtl/uart_wake_pkg.sv
// Package: types shared by the serial receiver and its submodules.
// Assumes nothing beyond being compiled before every module that imports it.
package uart_wake_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
// Module: brings the asynchronous line into the clock domain through a chain
// of flops. Assumes the idle level of the line is high.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer stages.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
// Module: hunts for a start bit, times each bit with a sample counter, votes
// three mid-bit samples and assembles the character LSB first.
// Assumes samp_en is one clock wide at OVS samples per bit and that rx_s is
// already synchronized.
module uart_rx_framer
    import uart_wake_pkg::*;
#(
    parameter int OVS     = 16,
    parameter int MAXBITS = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               samp_en,
    input  logic               rx_s,
    input  logic               len9,
    output logic [MAXBITS-1:0] chr,
    output logic               done,
    output logic               frm_bad,
    output logic               start_ok,
    output logic               in_hunt,
    output logic               in_start
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(MAXBITS);
    localparam logic [SW-1:0] S_A    = SW'(OVS/2 - 2);
    localparam logic [SW-1:0] S_B    = SW'(OVS/2 - 1);
    localparam logic [SW-1:0] S_C    = SW'(OVS/2);
    localparam logic [SW-1:0] S_LAST = SW'(OVS - 1);
    localparam logic [BW-1:0] LAST_L = BW'(MAXBITS - 1);
    localparam logic [BW-1:0] LAST_S = BW'(MAXBITS - 2);

    rx_state_e     state;
    logic [SW-1:0] scnt;
    logic [BW-1:0] bidx;
    logic [BW-1:0] last_idx;
    logic          v_a, v_b, vote;

    // Majority of the two stored samples and the present one.
    assign vote     = (v_a & v_b) | (v_a & rx_s) | (v_b & rx_s);
    assign last_idx = len9 ? LAST_L : LAST_S;
    assign in_hunt  = (state == ST_HUNT);
    assign in_start = (state == ST_START);

    // Bit timing, sampling, voting and frame sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            scnt     <= '0;
            bidx     <= '0;
            v_a      <= 1'b1;
            v_b      <= 1'b1;
            chr      <= '0;
            done     <= 1'b0;
            frm_bad  <= 1'b0;
            start_ok <= 1'b0;
        end else begin
            done     <= 1'b0;
            start_ok <= 1'b0;
            if (samp_en) begin
                if (state == ST_HUNT) begin
                    if (!rx_s) begin
                        state <= ST_START;
                        scnt  <= SW'(1);
                    end
                end else begin
                    scnt <= (scnt == S_LAST) ? '0 : scnt + 1'b1;
                    if (scnt == S_A) v_a <= rx_s;
                    if (scnt == S_B) v_b <= rx_s;
                    if (scnt == S_C) begin
                        case (state)
                            ST_START: begin
                                if (vote) begin
                                    state <= ST_HUNT;
                                end else begin
                                    start_ok <= 1'b1;
                                    chr      <= '0;
                                end
                            end
                            ST_DATA: begin
                                for (int i = 0; i < MAXBITS; i++) begin
                                    if (bidx == BW'(i)) chr[i] <= vote;
                                end
                            end
                            ST_STOP: begin
                                done    <= 1'b1;
                                frm_bad <= ~vote;
                                state   <= ST_HUNT;
                            end
                            default: ;
                        endcase
                    end
                    if (scnt == S_LAST) begin
                        case (state)
                            ST_START: begin
                                state <= ST_DATA;
                                bidx  <= '0;
                            end
                            ST_DATA: begin
                                if (bidx == last_idx) state <= ST_STOP;
                                else                  bidx  <= bidx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_idle.sv
// Module: counts consecutive high samples from the point chosen by
// after_stop and reports one idle hit per idle period. It is armed by an
// accepted start bit. Assumes in_hunt, in_start and start_ok come from the framer.
module uart_rx_idle #(
    parameter int OVS     = 16,
    parameter int MAXBITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic rx_s,
    input  logic len9,
    input  logic after_stop,
    input  logic in_hunt,
    input  logic in_start,
    input  logic start_ok,
    output logic idle_hit
);
    localparam int CW = $clog2((MAXBITS + 2) * OVS + 1);
    localparam logic [CW-1:0] LIM_S = CW'((MAXBITS + 1) * OVS);
    localparam logic [CW-1:0] LIM_L = CW'((MAXBITS + 2) * OVS);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          count_en;
    logic          armed;

    assign limit    = len9 ? LIM_L : LIM_S;
    assign count_en = after_stop ? in_hunt : ~in_start;
    assign idle_hit = samp_en & rx_s & count_en & armed & (cnt == limit - 1'b1);

    // Saturating run length of high samples inside the counting window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (samp_en) begin
            if (!rx_s || !count_en) cnt <= '0;
            else if (cnt < limit)   cnt <= cnt + 1'b1;
        end
    end

    // Arm on each accepted start bit, disarm once an idle has been reported.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (start_ok) armed <= 1'b1;
        else if (idle_hit) armed <= 1'b0;
    end
endmodule

// File: rtl/uart_wake_rx.sv
// Module: top of the serial receiver. It checks parity, registers each
// character with its error flags, and runs standby with address-mark or
// idle-line wakeup.
// Assumes samp_en is a one-clock tick at OVS times the bit rate.
module uart_wake_rx #(
    parameter int OVS         = 16,
    parameter int MAXBITS     = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               samp_en,
    input  logic               rxd,
    input  logic               cfg_len9,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_wake_addr,
    input  logic               cfg_idle_after_stop,
    input  logic               sleep_req,
    output logic [MAXBITS-1:0] rx_data,
    output logic               rx_valid,
    output logic               err_parity,
    output logic               err_frame,
    output logic               idle_flag,
    output logic               standby
);
    logic               rx_s;
    logic [MAXBITS-1:0] chr, chr_m;
    logic               done, frm_bad, start_ok, in_hunt, in_start;
    logic               idle_hit, par_c, msb_c, addr_wake, idle_wake, deliver;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    uart_rx_framer #(.OVS(OVS), .MAXBITS(MAXBITS)) u_framer (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_s(rx_s),
        .len9(cfg_len9), .chr(chr), .done(done), .frm_bad(frm_bad),
        .start_ok(start_ok), .in_hunt(in_hunt), .in_start(in_start)
    );

    uart_rx_idle #(.OVS(OVS), .MAXBITS(MAXBITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_s(rx_s),
        .len9(cfg_len9), .after_stop(cfg_idle_after_stop),
        .in_hunt(in_hunt), .in_start(in_start), .start_ok(start_ok),
        .idle_hit(idle_hit)
    );

    // Character as received, the top position cleared for the short length.
    assign chr_m     = cfg_len9 ? chr : {1'b0, chr[MAXBITS-2:0]};
    assign par_c     = cfg_par_en & ((^chr_m) ^ cfg_par_odd);
    assign msb_c     = cfg_len9 ? chr[MAXBITS-1] : chr[MAXBITS-2];
    assign addr_wake = standby & done & cfg_wake_addr & msb_c;
    assign idle_wake = standby & ~cfg_wake_addr & idle_hit;
    assign deliver   = done & (~standby | addr_wake);

    // Output register: data, flags and strobes for delivered characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            idle_flag  <= 1'b0;
        end else begin
            rx_valid  <= deliver;
            idle_flag <= idle_hit;
            if (deliver) begin
                rx_data    <= chr_m;
                err_parity <= par_c;
                err_frame  <= frm_bad;
            end
        end
    end

    // Standby: the request sets it, the selected wakeup clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                      standby <= 1'b0;
        else if (sleep_req)              standby <= 1'b1;
        else if (addr_wake || idle_wake) standby <= 1'b0;
    end
endmodule

// File: rtl/uart_wake_rx_chk.sv
// Module: assertion checker bound to the receiver top. It watches the
// strobes, the standby transitions and when the error flags change.
// Assumes the samp_en spacing given in the brief.
module uart_wake_rx_chk #(
    parameter int MAXBITS = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_len9,
    input logic               cfg_wake_addr,
    input logic               sleep_req,
    input logic [MAXBITS-1:0] rx_data,
    input logic               rx_valid,
    input logic               err_parity,
    input logic               err_frame,
    input logic               idle_flag,
    input logic               standby
);
    assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_frame_flag_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_frame) |-> rx_valid);

    assert_parity_flag_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_parity) |-> rx_valid);

    assert_standby_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(sleep_req));

    assert_valid_not_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!standby || $past(sleep_req)));

    assert_addr_wake_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(standby) && $past(cfg_wake_addr)) |->
        ($past(cfg_len9) ? rx_data[MAXBITS-1] : rx_data[MAXBITS-2]));

    assert_standby_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> (idle_flag || rx_valid));

    assert_idle_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |=> !idle_flag);
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.MAXBITS(MAXBITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_len9(cfg_len9), .cfg_wake_addr(cfg_wake_addr),
    .sleep_req(sleep_req), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_parity(err_parity), .err_frame(err_frame), .idle_flag(idle_flag),
    .standby(standby)
);

// File: tb/uart_wake_rx_tb.sv
// Bench: directed scenarios, one task each, each checking its own results.
module uart_wake_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len9 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_wake_addr = 1'b0, cfg_idle_after_stop = 1'b0, sleep_req = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, err_parity, err_frame, idle_flag, standby;

    int checks = 0, errors = 0;
    int n_valid = 0, n_idle = 0;
    logic [8:0] last_data = '0;
    logic last_perr = 1'b0, last_ferr = 1'b0;
    bit done_flag = 1'b0;

    uart_wake_rx u_dut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .cfg_len9(cfg_len9), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_wake_addr(cfg_wake_addr), .cfg_idle_after_stop(cfg_idle_after_stop),
        .sleep_req(sleep_req), .rx_data(rx_data), .rx_valid(rx_valid),
        .err_parity(err_parity), .err_frame(err_frame), .idle_flag(idle_flag),
        .standby(standby)
    );

    always #10 clk = ~clk;

    // Sample tick: one clock in every four.
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            samp_en = (k == 0);
            k = (k + 1) % 4;
        end
    end

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            n_valid   <= n_valid + 1;
            last_data <= rx_data;
            last_perr <= err_parity;
            last_ferr <= err_frame;
        end
        if (idle_flag) n_idle <= n_idle + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int nb);
        repeat (nb * 64) @(negedge clk);
    endtask

    // One frame: start, nb character bits, stop; optional glitch and parity flip.
    task automatic send_frame(input logic [8:0] ch, input int nb, input logic stop_v,
                              input int gap, input int gl_bit, input int gl_len,
                              input int flip_bit);
        for (int b = 0; b < nb + 2; b++) begin
            logic lv;
            lv = (b == 0) ? 1'b0 : ((b == nb + 1) ? stop_v : ch[b-1]);
            if (b == flip_bit) cfg_par_odd = ~cfg_par_odd;
            for (int s = 0; s < 16; s++) begin
                rxd = (b == gl_bit && s >= 7 && s < 7 + gl_len) ? ~lv : lv;
                repeat (4) @(negedge clk);
            end
        end
        rxd = 1'b1;
        wait_bits(gap);
    endtask

    task automatic simple(input logic [8:0] ch, input int nb, input int gap);
        send_frame(ch, nb, 1'b1, gap, -1, 0, -1);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 rx_valid", 32'(rx_valid), 0);
        chk("R13 rx_data", 32'(rx_data), 0);
        chk("R13 err flags", 32'({err_parity, err_frame}), 0);
        chk("R13 idle/standby", 32'({idle_flag, standby}), 0);
        wait_bits(15);
        chk("R11 no idle before first start", 32'(n_idle), 0);
    endtask

    task automatic t_fmt8();
        int v0;
        cfg_len9 = 0; cfg_par_en = 0;
        v0 = n_valid;
        simple(9'h0A5, 8, 2);
        chk("R1 count", 32'(n_valid - v0), 1);
        chk("R1 data", 32'(last_data), 32'h0A5);
        chk("R1 flags", 32'({last_perr, last_ferr}), 0);
        simple(9'h05A, 8, 12);
        chk("R1 data 2", 32'(last_data), 32'h05A);
    endtask

    task automatic t_fmt9();
        cfg_len9 = 1; cfg_par_en = 0;
        simple(9'h1A5, 9, 12);
        chk("R2 data", 32'(last_data), 32'h1A5);
        chk("R2 flags", 32'({last_perr, last_ferr}), 0);
    endtask

    task automatic t_par7();
        cfg_len9 = 0; cfg_par_en = 1; cfg_par_odd = 0;
        simple(9'h035, 8, 2);
        chk("R3 good data", 32'(last_data), 32'h035);
        chk("R3 good parity", 32'(last_perr), 0);
        simple(9'h0B5, 8, 12);
        chk("R3 bad data", 32'(last_data), 32'h0B5);
        chk("R3 bad parity", 32'(last_perr), 1);
    endtask

    task automatic t_par8();
        cfg_len9 = 1; cfg_par_en = 1; cfg_par_odd = 1;
        simple(9'h15A, 9, 2);
        chk("R4 R5 odd good", 32'({last_data, last_perr}), 32'({9'h15A, 1'b0}));
        simple(9'h05A, 9, 12);
        chk("R4 R5 odd bad", 32'({last_data, last_perr}), 32'({9'h05A, 1'b1}));
    endtask

    task automatic t_par_off();
        cfg_len9 = 0; cfg_par_en = 0; cfg_par_odd = 1;
        simple(9'h081, 8, 12);
        chk("R5 parity ignored", 32'({last_data, last_perr}), 32'({9'h081, 1'b0}));
        cfg_par_odd = 0;
    endtask

    task automatic t_frame();
        int v0;
        cfg_len9 = 0; cfg_par_en = 0;
        v0 = n_valid;
        send_frame(9'h03C, 8, 1'b0, 2, -1, 0, -1);
        chk("R6 framing set", 32'({last_data, last_ferr}), 32'({9'h03C, 1'b1}));
        simple(9'h0C3, 8, 12);
        chk("R6 framing clear", 32'({last_data, last_ferr}), 32'({9'h0C3, 1'b0}));
        chk("R6 both delivered", 32'(n_valid - v0), 2);
    endtask

    task automatic t_vote();
        int v0;
        cfg_len9 = 0; cfg_par_en = 0;
        send_frame(9'h000, 8, 1'b1, 2, 4, 1, -1);
        chk("R7 single glitch ignored", 32'(last_data), 32'h000);
        send_frame(9'h000, 8, 1'b1, 2, 4, 2, -1);
        chk("R7 double glitch flips", 32'(last_data), 32'h008);
        v0 = n_valid;
        rxd = 1'b0;
        repeat (4 * 4) @(negedge clk);
        rxd = 1'b1;
        wait_bits(12);
        chk("R7 false start rejected", 32'(n_valid - v0), 0);
        simple(9'h066, 8, 12);
        chk("R7 after false start", 32'({last_data, 9'(n_valid - v0)}), 32'({9'h066, 9'd1}));
    endtask

    task automatic t_wake_addr();
        int v0;
        cfg_len9 = 0; cfg_par_en = 0; cfg_wake_addr = 1;
        pulse_sleep();
        chk("R8 standby set", 32'(standby), 1);
        v0 = n_valid;
        simple(9'h041, 8, 12);
        chk("R8 no data in standby", 32'(n_valid - v0), 0);
        chk("R8 idle does not wake", 32'(standby), 1);
        simple(9'h085, 8, 2);
        chk("R8 mark delivered", 32'({last_data, 9'(n_valid - v0)}), 32'({9'h085, 9'd1}));
        chk("R8 standby cleared", 32'(standby), 0);
        cfg_len9 = 1;
        pulse_sleep();
        simple(9'h0FF, 9, 2);
        chk("R8 long top bit 0 held", 32'({standby, 9'(n_valid - v0)}), 32'({1'b1, 9'd1}));
        simple(9'h101, 9, 12);
        chk("R8 long mark wakes", 32'({standby, last_data}), 32'({1'b0, 9'h101}));
        cfg_len9 = 0; cfg_wake_addr = 0;
    endtask

    task automatic t_wake_idle();
        int v0;
        cfg_len9 = 0; cfg_par_en = 0; cfg_wake_addr = 0; cfg_idle_after_stop = 0;
        pulse_sleep();
        v0 = n_valid;
        simple(9'h080, 8, 2);
        chk("R9 no data in standby", 32'({standby, 9'(n_valid - v0)}), 32'({1'b1, 9'd0}));
        wait_bits(12);
        chk("R9 idle wakes", 32'({standby, 9'(n_valid - v0)}), 32'({1'b0, 9'd0}));
        simple(9'h012, 8, 12);
        chk("R9 data after wake", 32'({last_data, 9'(n_valid - v0)}), 32'({9'h012, 9'd1}));
    endtask

    task automatic t_idle_type();
        int i0;
        cfg_len9 = 0; cfg_par_en = 0;
        cfg_idle_after_stop = 0;
        i0 = n_idle;
        simple(9'h0FF, 8, 2);
        chk("R10 count from start bit", 32'(n_idle - i0), 1);
        wait_bits(12);
        cfg_idle_after_stop = 1;
        i0 = n_idle;
        simple(9'h0FF, 8, 2);
        chk("R10 count from stop bit, early", 32'(n_idle - i0), 0);
        wait_bits(12);
        chk("R10 count from stop bit, later", 32'(n_idle - i0), 1);
    endtask

    task automatic t_idle_once();
        int i0;
        cfg_len9 = 1; cfg_idle_after_stop = 1;
        i0 = n_idle;
        simple(9'h055, 9, 30);
        chk("R11 once per idle", 32'(n_idle - i0), 1);
        simple(9'h0AA, 9, 13);
        chk("R11 rearmed by start", 32'(n_idle - i0), 2);
        cfg_len9 = 0; cfg_idle_after_stop = 0;
    endtask

    task automatic t_pty_change();
        int v0;
        cfg_len9 = 1; cfg_par_en = 1; cfg_par_odd = 0;
        v0 = n_valid;
        send_frame(9'h033, 9, 1'b1, 2, -1, 0, 4);
        chk("R12 flipped char delivered", 32'(last_data), 32'h033);
        simple(9'h133, 9, 12);
        chk("R12 next char ok", 32'({last_data, last_perr}), 32'({9'h133, 1'b0}));
        chk("R12 count", 32'(n_valid - v0), 2);
        cfg_len9 = 0; cfg_par_en = 0; cfg_par_odd = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fmt8();
        t_fmt9();
        t_par7();
        t_par8();
        t_par_off();
        t_frame();
        t_vote();
        t_wake_addr();
        t_wake_idle();
        t_idle_type();
        t_idle_once();
        t_pty_change();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule